// File: doc/BRIEF.md
# Dual-Edge Pin Interrupt and Wakeup Detector

This block watches a bank of already-synchronized input pins and turns their transitions into interrupt and wakeup events. Each pin has four independent enables: one each for rising and for falling edges that raise the normal interrupt, and one each for rising and for falling edges that can wake the system. A pin that should respond to both directions has its bit set in both the rising and the falling register. There is no level-triggered mode.

Enabled interrupt edges latch into a pending register, one bit per pin. Software clears bits by writing ones to the pending register. The parent interrupt line is the OR of all pending bits. While the sleep input is high, an enabled wake edge on a pin whose sleep-control bit is 0 sets a per-pin wake record and raises the wakeup request. That request is independent of the interrupt enables and holds until sleep falls.

Top module: `gpio_edge_wake`

## Requirements
- R1: The register port uses these 3-bit addresses: 0 rising-interrupt enable, 1 falling-interrupt enable, 2 rising-wake enable, 3 falling-wake enable, 4 sleep control, 5 pending status (write 1 to clear), 6 wake record (read only), 7 sampled pin levels (read only). After reset, registers 0-3 and the pending status read 0, and sleep control reads all ones.
- R2: A rising event is a 0-to-1 change between consecutive clock samples of a pin. On the clock edge that samples it, the event sets the pin's pending bit when the pin's rising-interrupt enable bit is 1.
- R3: A falling event is a 1-to-0 change between consecutive samples. It sets the pending bit when the pin's falling-interrupt enable bit is 1. The rising and falling enables act independently, and a pin with both enables set reports both directions.
- R4: Writing to address 5 clears every pending bit written as 1. Bits written as 0 keep their value.
- R5: If an enabled edge and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R6: `irq` is high exactly while at least one pending bit is set. It stays high until the last pending bit is cleared.
- R7: While `sleep` is high, an edge whose wake enable for that direction is 1, on a pin whose sleep-control bit is 0, sets that pin's wake record bit and raises `wake_req` on the next clock edge. A sleep-control bit of 1 blocks wake detection on that pin.
- R8: Wake detection does not depend on the interrupt enables. A pin can raise `wake_req` while its interrupt enables are 0 and its pending bit stays clear.
- R9: `wake_req` and the wake record hold while `sleep` stays high. Both clear on the first clock edge that samples `sleep` low. Edges that occur while `sleep` is low are not recorded.
- R10: An edge whose enable bit for that direction is 0 leaves the pending status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | PINS | Synchronized pin levels |
| sleep | input | 1 | System sleep indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | PINS | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | PINS | Combinational read data |
| irq | output | 1 | Parent interrupt |
| wake_req | output | 1 | Wakeup request |

## Verification
Checked on every cycle:
- Pending bits appear only where a pin changed in the previous sample.
- A clear with no competing edge empties the bit.
- A competing edge beats a clear.
- `irq` cannot drop without a clear.
- New wake bits never land on pins whose sleep control is 1.
- `wake_req` holds during sleep and is low after an awake cycle.

Only the directed scenarios can show the rest:
- The address map and reset values.
- The separation of rising from falling enables.
- That writing zeros to the clear register has no effect.
- That wakeup works with the interrupt enables cleared.
- That edges seen while awake are not recorded.

// File: rtl/gpio_edge_wake.sv
module gpio_edge_wake #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_in,
  input  logic            sleep,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [PINS-1:0] wr_data,
  input  logic [2:0]      rd_addr,
  output logic [PINS-1:0] rd_data,
  output logic            irq,
  output logic            wake_req
);
  localparam logic [2:0] A_RIRQ = 3'd0, A_FIRQ = 3'd1, A_RWAKE = 3'd2, A_FWAKE = 3'd3;
  localparam logic [2:0] A_SCTL = 3'd4, A_PEND = 3'd5, A_WREC = 3'd6, A_PINS = 3'd7;
  localparam logic [PINS-1:0] ONES = {PINS{1'b1}};

  logic [PINS-1:0] pin_q, rise_ie, fall_ie, rise_we, fall_we, slp_ctl, pend, wrec;

  wire [PINS-1:0] rise_ev = pin_in & ~pin_q;
  wire [PINS-1:0] fall_ev = ~pin_in & pin_q;
  wire [PINS-1:0] setv    = (rise_ev & rise_ie) | (fall_ev & fall_ie);
  wire [PINS-1:0] clrv    = (wr_en && wr_addr == A_PEND) ? wr_data : '0;
  wire [PINS-1:0] wake_hit = ((rise_ev & rise_we) | (fall_ev & fall_we)) & ~slp_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= '0;
      rise_ie <= '0;
      fall_ie <= '0;
      rise_we <= '0;
      fall_we <= '0;
      slp_ctl <= ONES;
      pend    <= '0;
      wrec    <= '0;
    end else begin
      pin_q <= pin_in;
      pend  <= (pend & ~clrv) | setv;
      wrec  <= sleep ? (wrec | wake_hit) : '0;
      if (wr_en) begin
        case (wr_addr)
          A_RIRQ:  rise_ie <= wr_data;
          A_FIRQ:  fall_ie <= wr_data;
          A_RWAKE: rise_we <= wr_data;
          A_FWAKE: fall_we <= wr_data;
          A_SCTL:  slp_ctl <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_RIRQ:  rd_data = rise_ie;
      A_FIRQ:  rd_data = fall_ie;
      A_RWAKE: rd_data = rise_we;
      A_FWAKE: rd_data = fall_we;
      A_SCTL:  rd_data = slp_ctl;
      A_PEND:  rd_data = pend;
      A_WREC:  rd_data = wrec;
      A_PINS:  rd_data = pin_q;
      default: rd_data = '0;
    endcase
  end

  assign irq      = |pend;
  assign wake_req = |wrec;

  // R2, R3: pending bits only appear on pins that changed
  a_r2_edge_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(pin_in ^ pin_q)) == '0);

  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clrv & ~setv) != '0 |=> (pend & $past(clrv & ~setv)) == '0);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    setv != '0 |=> (pend & $past(setv)) == $past(setv));

  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq && clrv == '0 |=> irq);

  a_r7_sctl_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wrec & ~$past(wrec) & $past(slp_ctl)) == '0);

  a_r9_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req && sleep |=> wake_req);

  a_r9_wake_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> !wake_req);
endmodule

// File: tb/tb_gpio_edge_wake.sv
module tb_gpio_edge_wake;
  localparam int PINS = 32;
  logic clk = 0, rst_n = 0, sleep = 0, wr_en = 0;
  logic [PINS-1:0] pin_in = '0, wr_data = '0, rd_data;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic irq, wake_req;
  int total = 0, bad = 0;
  bit done = 0;

  gpio_edge_wake #(.PINS(PINS)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [PINS-1:0] got, logic [PINS-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [PINS-1:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic chk_reg(string req, logic [2:0] a, logic [PINS-1:0] exp);
    logic [PINS-1:0] v;
    rd(a, v); chk(req, v, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [PINS-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic set_pin(int i, logic v);
    pin_in[i] = v; step();
  endtask

  task automatic t_reset();
    chk_reg("R1 rise irq", 3'd0, '0);
    chk_reg("R1 fall irq", 3'd1, '0);
    chk_reg("R1 rise wake", 3'd2, '0);
    chk_reg("R1 fall wake", 3'd3, '0);
    chk_reg("R1 sleep ctl", 3'd4, '1);
    chk_reg("R1 pending", 3'd5, '0);
    chk("R6 irq reset", irq, 0);
    chk("R9 wake reset", wake_req, 0);
    pin_in = 32'h0000_00f0; step();
    chk_reg("R1 pin levels", 3'd7, 32'h0000_00f0);
    chk_reg("R10 no enables", 3'd5, '0);
    pin_in = '0; step();
  endtask

  task automatic t_rise();
    wr(3'd0, 32'h0000_0008);
    set_pin(3, 1);
    chk_reg("R2 rise sets", 3'd5, 32'h8);
    chk("R6 irq up", irq, 1);
    wr(3'd5, 32'h8);
    set_pin(3, 0);
    chk_reg("R10 fall disabled", 3'd5, '0);
    chk("R6 irq down", irq, 0);
  endtask

  task automatic t_fall();
    wr(3'd1, 32'h0000_0020);
    set_pin(5, 1);
    chk_reg("R3 rise ignored", 3'd5, '0);
    set_pin(5, 0);
    chk_reg("R3 fall sets", 3'd5, 32'h20);
  endtask

  task automatic t_both();
    wr(3'd0, 32'h0000_0088);
    wr(3'd1, 32'h0000_00a0);
    set_pin(7, 1);
    chk_reg("R3 both rise", 3'd5, 32'ha0);
    wr(3'd5, 32'h80);
    chk_reg("R4 cleared 7", 3'd5, 32'h20);
    set_pin(7, 0);
    chk_reg("R3 both fall", 3'd5, 32'ha0);
    wr(3'd5, 32'h80);
  endtask

  task automatic t_clear();
    set_pin(3, 1);
    chk_reg("R2 setup", 3'd5, 32'h28);
    wr(3'd5, 32'h0);
    chk_reg("R4 zeros keep", 3'd5, 32'h28);
    wr(3'd5, 32'h8);
    chk_reg("R4 partial", 3'd5, 32'h20);
    chk("R6 irq stays", irq, 1);
    wr(3'd5, 32'h20);
    chk_reg("R4 all clear", 3'd5, '0);
    chk("R6 irq clears", irq, 0);
    set_pin(3, 0);
  endtask

  task automatic t_set_wins();
    wr(3'd0, 32'h0000_0200);
    pin_in[9] = 1;
    wr(3'd5, 32'h200);
    chk_reg("R5 set wins", 3'd5, 32'h200);
    wr(3'd5, 32'h200);
    chk_reg("R5 later clear", 3'd5, '0);
    set_pin(9, 0);
  endtask

  task automatic t_wake();
    wr(3'd0, '0); wr(3'd1, '0);
    wr(3'd2, 32'h0000_3000);
    wr(3'd3, 32'h0000_1000);
    wr(3'd4, 32'hffff_efff);
    sleep = 1; step();
    set_pin(12, 1);
    chk("R7 wake up", wake_req, 1);
    chk_reg("R7 record", 3'd6, 32'h1000);
    chk_reg("R8 no pending", 3'd5, '0);
    chk("R8 no irq", irq, 0);
    step(); step();
    chk("R9 wake held", wake_req, 1);
    sleep = 0; step();
    chk("R9 wake drop", wake_req, 0);
    chk_reg("R9 record clear", 3'd6, '0);
  endtask

  task automatic t_wake_blocked();
    set_pin(12, 0);
    sleep = 1; step();
    chk("R9 awake edge ignored", wake_req, 0);
    set_pin(13, 1);
    chk("R7 sleep ctl blocks", wake_req, 0);
    chk_reg("R7 no record", 3'd6, '0);
    set_pin(12, 1);
    chk("R7 rise wake only", wake_req, 1);
    sleep = 0; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_clear();
    t_set_wins();
    t_wake();
    t_wake_blocked();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule